// File: doc/BRIEF.md
# Real-Time Clock Register Interface

This block puts a small real-time-clock register file behind two byte-wide ports. Software first writes a register number to the index port. It then reads or writes the selected register through the data port. The register file has three parts: ten time-of-day bytes at the lowest numbers, a rate-control register at 0xA and a mode-control register at 0xB.

The two control registers accept only the single configuration that the block supports. Any other value is refused, leaves the register unchanged and raises a one-cycle error pulse. The same error pulse covers an index above 0xD and any access to 0xC or 0xD. Every read of the rate-control register flips its update-in-progress flag, so software that polls for an edge of that flag always sees one.

The periodic-interrupt-enable bit of the mode register controls a periodic timer. When the timer runs, it emits a one-cycle interrupt pulse every `PERIOD_CYCLES` clocks. The default value is the 1024 Hz period at a 50 MHz system clock.

Top module: `rtc_index_port`

## Requirements
- R1: After reset the following hold:
  - The index is 0 and the ten clock bytes are 0.
  - The rate register holds 0x26, so its first read returns 0xA6.
  - The mode register holds 0x46.
  - `periodicIrq` stays low until a mode-register write with bit 6 set starts the timer.
- R2: A write of a value from 0x0 to 0xD on the index port (`selData`=0) loads the index. A read of the index port returns the index in bits 3:0, with bits 7:4 zero.
- R3: A write above 0xD on the index port raises `errPulse` for one cycle and leaves the index unchanged.
- R4: With the index below 0xA, data-port writes store the byte into the selected clock byte, and data-port reads return it.
- R5: A data-port write to register 0xA is accepted only when the value is exactly 0x26, and the accepted write clears bit 7. Any other value raises `errPulse` and leaves the register unchanged.
- R6: Each data-port read of register 0xA inverts bit 7 (update in progress) of the stored value and returns the inverted value. Bits 6:0 read as 0x26.
- R7: A data-port write to register 0xB is accepted and stored only when `(value & 0xB7) == 0x06`, so bits 6 (interrupt enable) and 3 (square wave) are free. Any other value raises `errPulse` and leaves the register unchanged.
- R8: An accepted 0xB write with bit 6 set starts an idle timer. The first `periodicIrq` pulse then comes `PERIOD_CYCLES` cycles after the write edge, and a pulse follows every `PERIOD_CYCLES` after that. The same write to a running timer does not restart it.
- R9: An accepted 0xB write with bit 6 clear stops the timer. `periodicIrq` then stays low.
- R10: Any data-port access with the index at 0xC or 0xD raises `errPulse`. Such a read returns 0x00 with `rdValid`.
- R11: A read returns `rdData` with `rdValid` high one cycle after `rdEn`. When `wrEn` and `rdEn` are high together, the write is performed, the read is dropped and `rdValid` stays low.
- R12: `periodicIrq` is high for exactly one cycle per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| selData | input | 1 | 0 selects the index port, 1 selects the data port |
| wrEn | input | 1 | Write strobe for the selected port |
| rdEn | input | 1 | Read strobe for the selected port |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Read byte, valid with `rdValid` |
| rdValid | output | 1 | One-cycle flag marking a read result |
| errPulse | output | 1 | One-cycle flag for a refused or illegal access |
| periodicIrq | output | 1 | One-cycle periodic interrupt pulse |

## Verification
The assertions check the following on every cycle:
- The stored control registers never leave their single legal pattern.
- A refused index write leaves the index stable and raises the error.
- Accesses to 0xC and 0xD are flagged.
- Read timing and write priority hold.
- The interrupt is a single-cycle pulse, and it is silent after a stop.

Other behaviour only the bench scenarios can show. This covers the exact pulse spacing after a start, and that a repeated enable does not restart the timer. It also covers the alternating update-in-progress value across sweeps of every byte written to both control registers, and the round trip of the clock bytes.

// File: rtl/rtc_port_pkg.sv
package rtc_port_pkg;
  localparam int IDX_W = 4;
  localparam logic [IDX_W-1:0] IDX_REGA = 4'hA;
  localparam logic [IDX_W-1:0] IDX_REGB = 4'hB;
  localparam logic [IDX_W-1:0] IDX_TOP  = 4'hD;

  localparam logic [7:0] REGA_LEGAL    = 8'h26;  // 32.768 kHz base, 1024 Hz rate
  localparam logic [7:0] REGA_UIP      = 8'h80;
  localparam logic [7:0] REGB_RESET    = 8'h46;  // irq enable, binary, 24 h
  localparam logic [7:0] REGB_FREE     = 8'h48;  // irq enable and square wave
  localparam logic [7:0] REGB_REQUIRED = 8'h06;  // binary and 24 h
  localparam int         PIE_POS       = 6;

  typedef enum logic [2:0] {
    RD_NONE, RD_INDEX, RD_CLOCK, RD_REGA, RD_REGB, RD_ZERO
  } rdKind_t;

  typedef struct packed {
    logic    idxLoad;
    logic    clkWrite;
    logic    aWrite;
    logic    bWrite;
    logic    timerStart;
    logic    timerStop;
    logic    err;
    rdKind_t rdKind;
  } rtcStrobe_t;
endpackage

// File: rtl/rtc_port_ctrl.sv
module rtc_port_ctrl
  import rtc_port_pkg::*;
#(
  parameter int CLK_BYTES = 10  // must not exceed 10
) (
  input  logic             selData,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [7:0]       wrData,
  input  logic [IDX_W-1:0] curIndex,
  output rtcStrobe_t       stb
);
  localparam logic [IDX_W-1:0] CLK_END = IDX_W'(CLK_BYTES);

  logic isClock, isRegA, isRegB;
  assign isClock = curIndex < CLK_END;
  assign isRegA  = curIndex == IDX_REGA;
  assign isRegB  = curIndex == IDX_REGB;

  always_comb begin
    stb        = '0;
    stb.rdKind = RD_NONE;
    if (wrEn) begin
      if (!selData) begin
        if (wrData <= {4'h0, IDX_TOP}) stb.idxLoad = 1'b1;
        else                           stb.err     = 1'b1;
      end else if (isClock) begin
        stb.clkWrite = 1'b1;
      end else if (isRegA) begin
        if (wrData == REGA_LEGAL) stb.aWrite = 1'b1;
        else                      stb.err    = 1'b1;
      end else if (isRegB) begin
        if ((wrData & ~REGB_FREE) == REGB_REQUIRED) begin
          stb.bWrite     = 1'b1;
          stb.timerStart = wrData[PIE_POS];
          stb.timerStop  = !wrData[PIE_POS];
        end else begin
          stb.err = 1'b1;
        end
      end else begin
        stb.err = 1'b1;
      end
    end else if (rdEn) begin
      if (!selData)    stb.rdKind = RD_INDEX;
      else if (isClock) stb.rdKind = RD_CLOCK;
      else if (isRegA)  stb.rdKind = RD_REGA;
      else if (isRegB)  stb.rdKind = RD_REGB;
      else begin
        stb.rdKind = RD_ZERO;
        stb.err    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_port_dpath.sv
module rtc_port_dpath
  import rtc_port_pkg::*;
#(
  parameter int CLK_BYTES = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  rtcStrobe_t       stb,
  input  logic [7:0]       wrData,
  output logic [IDX_W-1:0] curIndex,
  output logic [7:0]       rdData,
  output logic             rdValid,
  output logic             errPulse
);
  logic [7:0] clkMem [CLK_BYTES];
  logic [7:0] regA, regB;
  logic [7:0] regAFlip;

  assign regAFlip = regA ^ REGA_UIP;

  for (genvar g = 0; g < CLK_BYTES; g++) begin : gClockByte
    always_ff @(posedge clk) begin
      if (!rstN)                                         clkMem[g] <= '0;
      else if (stb.clkWrite && curIndex == IDX_W'(g))    clkMem[g] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIndex <= '0;
      regA     <= REGA_LEGAL;
      regB     <= REGB_RESET;
      rdData   <= '0;
      rdValid  <= 1'b0;
      errPulse <= 1'b0;
    end else begin
      errPulse <= stb.err;
      rdValid  <= stb.rdKind != RD_NONE;
      if (stb.idxLoad) curIndex <= wrData[IDX_W-1:0];
      if (stb.aWrite)  regA     <= wrData;
      if (stb.bWrite)  regB     <= wrData;
      case (stb.rdKind)
        RD_INDEX: rdData <= {{(8-IDX_W){1'b0}}, curIndex};
        RD_CLOCK: rdData <= clkMem[curIndex];
        RD_REGA: begin
          regA   <= regAFlip;
          rdData <= regAFlip;
        end
        RD_REGB: rdData <= regB;
        RD_ZERO: rdData <= '0;
        default: rdData <= rdData;
      endcase
    end
  end

  // R5: the rate register keeps its single legal setting apart from bit 7
  a_r5_rega_legal: assert property (@(posedge clk) disable iff (!rstN)
    regA[6:0] == REGA_LEGAL[6:0]);
  // R7: the mode register only ever varies in its two free bits
  a_r7_regb_legal: assert property (@(posedge clk) disable iff (!rstN)
    (regB & ~REGB_FREE) == REGB_REQUIRED);
  // R2: the index never exceeds the top register number
  a_r2_index_range: assert property (@(posedge clk) disable iff (!rstN)
    curIndex <= IDX_TOP);
endmodule

// File: rtl/rtc_port_timer.sv
module rtc_port_timer #(
  parameter int PERIOD_CYCLES = 48828
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic stop,
  output logic irq
);
  localparam int CNT_W = (PERIOD_CYCLES > 2) ? $clog2(PERIOD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD_CYCLES - 1);

  logic             running;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      cnt     <= '0;
      irq     <= 1'b0;
    end else if (stop) begin
      running <= 1'b0;
      cnt     <= '0;
      irq     <= 1'b0;
    end else if (start && !running) begin
      running <= 1'b1;
      cnt     <= '0;
      irq     <= 1'b0;
    end else if (running) begin
      if (cnt == CNT_LAST) begin
        cnt <= '0;
        irq <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
        irq <= 1'b0;
      end
    end else begin
      irq <= 1'b0;
    end
  end

  // R12: a pulse lasts one cycle
  a_r12_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
  // R9: a stop silences the next cycle
  a_r9_stop_quiet: assert property (@(posedge clk) disable iff (!rstN)
    stop |=> !irq);
  // R8: pulses only come from a running timer
  a_r8_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> running);
endmodule

// File: rtl/rtc_index_port.sv
module rtc_index_port
  import rtc_port_pkg::*;
#(
  parameter int CLK_BYTES     = 10,
  parameter int PERIOD_CYCLES = 48828
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       selData,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       rdValid,
  output logic       errPulse,
  output logic       periodicIrq
);
  rtcStrobe_t       stb;
  logic [IDX_W-1:0] curIndex;

  rtc_port_ctrl #(.CLK_BYTES(CLK_BYTES)) ctrl_i (
    .selData(selData), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .curIndex(curIndex), .stb(stb)
  );

  rtc_port_dpath #(.CLK_BYTES(CLK_BYTES)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .curIndex(curIndex), .rdData(rdData), .rdValid(rdValid), .errPulse(errPulse)
  );

  rtc_port_timer #(.PERIOD_CYCLES(PERIOD_CYCLES)) timer_i (
    .clk(clk), .rstN(rstN), .start(stb.timerStart), .stop(stb.timerStop),
    .irq(periodicIrq)
  );

  // R3: an out-of-range index write is flagged and keeps the index
  a_r3_index_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !selData && wrData > 8'h0D) |=> (errPulse && $stable(curIndex)));
  // R10: registers C and D are illegal targets
  a_r10_cd_error: assert property (@(posedge clk) disable iff (!rstN)
    ((wrEn || rdEn) && selData && curIndex >= 4'hC) |=> errPulse);
  // R11: read result timing and write priority
  a_r11_rd_valid: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn) |=> rdValid);
  a_r11_wr_wins: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !rdValid);
endmodule

// File: tb/rtc_index_port_tb.sv
module rtc_index_port_tb_top;
  localparam int P = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       selData = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       rdValid, errPulse, periodicIrq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  rtc_index_port #(.CLK_BYTES(10), .PERIOD_CYCLES(P)) dut_i (
    .clk(clk), .rstN(rstN), .selData(selData), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid), .errPulse(errPulse),
    .periodicIrq(periodicIrq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic s, input logic w, input logic r, input logic [7:0] d);
    @(negedge clk);
    selData = s; wrEn = w; rdEn = r; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  task automatic setIdx(input logic [7:0] v);
    acc(1'b0, 1'b1, 1'b0, v);
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [3:0] idxModel;
    logic       uip;
    logic [7:0] bModel;
    bit         ok;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, timer idle even though enable reads as set
    chk("R1 irq", periodicIrq, 0);
    for (int k = 0; k < 2 * P; k++) begin
      @(negedge clk);
      chk("R1 irq idle", periodicIrq, 0);
    end
    acc(1'b0, 1'b0, 1'b1, 8'h0);
    chk("R1 index", rdData, 8'h00);
    chk("R11 valid", rdValid, 1);
    acc(1'b1, 1'b0, 1'b1, 8'h0);
    chk("R1 byte0", rdData, 8'h00);
    setIdx(8'h0A);
    acc(1'b1, 1'b0, 1'b1, 8'h0);
    chk("R1 regA", rdData, 8'hA6);
    uip = 1'b1;
    setIdx(8'h0B);
    acc(1'b1, 1'b0, 1'b1, 8'h0);
    chk("R1 regB", rdData, 8'h46);

    // R2 / R3: index sweep
    idxModel = 4'hB;
    for (int v = 0; v < 256; v += 7) begin
      setIdx(8'(v));
      chk("R3 err", errPulse, (v > 13) ? 1 : 0);
      if (v <= 13) idxModel = 4'(v);
      acc(1'b0, 1'b0, 1'b1, 8'h0);
      chk("R2 index", rdData, {4'h0, idxModel});
    end
    for (int v = 0; v < 16; v++) begin
      setIdx(8'(v));
      chk("R3 err", errPulse, (v > 13) ? 1 : 0);
      if (v <= 13) idxModel = 4'(v);
      acc(1'b0, 1'b0, 1'b1, 8'h0);
      chk("R2 index", rdData, {4'h0, idxModel});
    end

    // R4: clock bytes round trip
    for (int i = 0; i < 10; i++) begin
      setIdx(8'(i));
      acc(1'b1, 1'b1, 1'b0, 8'((i * 37 + 5) & 255));
      chk("R4 no err", errPulse, 0);
    end
    for (int i = 0; i < 10; i++) begin
      setIdx(8'(i));
      acc(1'b1, 1'b0, 1'b1, 8'h0);
      chk("R4 byte", rdData, 32'((i * 37 + 5) & 255));
    end

    // R5 / R6: rate register sweep
    setIdx(8'h0A);
    for (int v = 0; v < 256; v++) begin
      acc(1'b1, 1'b1, 1'b0, 8'(v));
      chk("R5 err", errPulse, (v != 8'h26) ? 1 : 0);
      if (v == 8'h26) uip = 1'b0;
      acc(1'b1, 1'b0, 1'b1, 8'h0);
      uip = ~uip;
      chk("R6 regA", rdData, {uip, 7'h26});
    end

    // R7: mode register sweep
    setIdx(8'h0B);
    bModel = 8'h46;
    for (int v = 0; v < 256; v++) begin
      ok = ((v & 8'hB7) == 8'h06);
      acc(1'b1, 1'b1, 1'b0, 8'(v));
      chk("R7 err", errPulse, ok ? 0 : 1);
      if (ok) bModel = 8'(v);
      acc(1'b1, 1'b0, 1'b1, 8'h0);
      chk("R7 regB", rdData, bModel);
    end

    // R9: stop, then quiet
    acc(1'b1, 1'b1, 1'b0, 8'h06);
    for (int k = 0; k < 2 * P; k++) begin
      @(negedge clk);
      chk("R9 quiet", periodicIrq, 0);
    end

    // R8 / R12: start; rewrite of enable at k=5 must not restart
    acc(1'b1, 1'b1, 1'b0, 8'h46);
    for (int k = 1; k <= 3 * P; k++) begin
      @(negedge clk);
      chk("R8 R12 pulse", periodicIrq, (k % P == 0) ? 1 : 0);
      if (k == 5) begin
        selData = 1'b1; wrData = 8'h4E; wrEn = 1'b1;
      end else begin
        wrEn = 1'b0;
      end
    end
    acc(1'b1, 1'b1, 1'b0, 8'h0E);
    for (int k = 0; k < 2 * P; k++) begin
      @(negedge clk);
      chk("R9 stopped", periodicIrq, 0);
    end

    // R10: registers C and D
    for (int r = 12; r <= 13; r++) begin
      setIdx(8'(r));
      acc(1'b1, 1'b1, 1'b0, 8'h55);
      chk("R10 wr err", errPulse, 1);
      acc(1'b1, 1'b0, 1'b1, 8'h0);
      chk("R10 rd err", errPulse, 1);
      chk("R10 rd zero", rdData, 8'h00);
      chk("R10 rd valid", rdValid, 1);
    end

    // R11: write wins over a simultaneous read
    setIdx(8'h03);
    acc(1'b1, 1'b1, 1'b1, 8'h5A);
    chk("R11 no valid", rdValid, 0);
    acc(1'b1, 1'b0, 1'b1, 8'h0);
    chk("R11 written", rdData, 8'h5A);
    chk("R11 valid", rdValid, 1);

    finishRun();
  end
endmodule